// File: doc/BRIEF.md
# Dual-Clock Compare-Match Timer

This block is a register-mapped timer. It has two clock domains. A 32-bit up-counter lives in a slow tick domain: it runs freely while enabled and wraps through zero. A register file lives in the faster host domain and is reached by single-cycle reads and writes. The host never touches the counter directly. It asks for a snapshot of the count, pushes a new compare value or pushes a new count value. Each of these requests crosses to the tick domain and back through a toggle handshake. A busy bit, visible to software, stays set for as long as that handshake is in flight.

Each handshake is run by a small two-state machine in the host domain, named `XF_IDLE` and `XF_WAIT`. When a request is accepted the machine goes from `XF_IDLE` to `XF_WAIT` and flips its request toggle. When the returning acknowledge edge arrives it goes back from `XF_WAIT` to `XF_IDLE` and raises a one-cycle done pulse. There are no other states or transitions. The tick domain compares the counter with its own copy of the compare value. A hit or a wrap is sent back as a toggle and sets a sticky flag. The interrupt line is the compare flag gated by an enable bit.

Register word indices on `host_addr`:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | control | run bit 0; bit 1 requests a snapshot |
| 1 | compare | compare value |
| 2 | count | load value on write; snapshot on read |
| 3 | flags | sticky flags, write 1 to clear |
| 4 | irq enable | bit 0 |
| 5 | busy | transfer busy bits |

Top module: `xmt_timer`

## Requirements
- R1: After reset the registers read as follows: compare 0xFFFFFFFF, count snapshot 0, flags 0, irq enable 0, control 0 (counter stopped) and busy 0. `irq` is low.
- R2: While control bit 0 is 1 the counter advances once per tick-clock cycle. While control bit 0 is 0 it holds its value, so two snapshots taken while it is stopped are equal.
- R3: A control write with bit 1 set starts a snapshot and sets busy bit 2 on the next host cycle. Busy bit 2 clears only once the count register (index 2) holds the counter value captured in the tick domain.
- R4: A write to the compare register sets busy bit 0 on the next host cycle. Busy bit 0 stays set until the tick domain has taken the value. Completion sets flag bit 3.
- R5: A write to the count register sets busy bit 1 until the counter has been loaded with the written value. Completion sets flag bit 2.
- R6: A compare, count or snapshot request made while its own busy bit is set is ignored. The compare register keeps the earlier value.
- R7: A running counter whose value equals the compare value sets flag bit 0. A running counter that steps from 0xFFFFFFFF to 0 sets flag bit 1.
- R8: Writing the flags register clears exactly the flags whose written bit is 1. If a flag's set event arrives in the same cycle as its clear, the set wins.
- R9: `irq` is high exactly when flag bit 0 and irq-enable bit 0 are both 1. It falls in the host cycle after a write that clears flag bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain asynchronous reset, active low |
| tclk | input | 1 | Tick clock for the counter |
| trst_n | input | 1 | Tick-domain asynchronous reset, active low |
| host_sel | input | 1 | Register access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the indexed register (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench first goes after back-to-back compare writes. A design that did not drop the second write would corrupt the compare value while the first transfer was still in flight, and the compare register would read back the wrong word. It then checks a compare value behind the counter, one far ahead of it, and one just past the wrap point. A comparator built on magnitude rather than equality, or a wrap detector on the wrong count, sets the wrong flags in those cases. It also checks a clear that names only one flag, which exposes a clear-all bug. Finally it checks the interrupt the cycle after a clear, which exposes an extra register stage on `irq`. Snapshots of a stopped counter must match the loaded value exactly, so a snapshot path that returned stale or half-captured data would show up there.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_CMP   = 3'd1,
        REG_COUNT = 3'd2,
        REG_FLAGS = 3'd3,
        REG_IEN   = 3'd4,
        REG_BUSY  = 3'd5
    } xmt_reg_e;

    localparam int XF_CMP  = 0;
    localparam int XF_LOAD = 1;
    localparam int XF_SNAP = 2;
    localparam int XF_N    = 3;

    localparam int FL_HIT    = 0;
    localparam int FL_WRAP   = 1;
    localparam int FL_LOADED = 2;
    localparam int FL_CMPSET = 3;
    localparam int FL_N      = 4;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xf_state_e;
endpackage

// File: rtl/xmt_sync2.sv
module xmt_sync2 #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xmt_xfer_fsm.sv
module xmt_xfer_fsm
    import xmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_pulse,
    output logic req_tgl,
    output logic busy,
    output logic done
);
    xf_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= XF_IDLE;
            req_tgl <= 1'b0;
        end else begin
            state <= nxt;
            if (state == XF_IDLE && start) req_tgl <= ~req_tgl;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            XF_IDLE: if (start)     nxt = XF_WAIT;
            XF_WAIT: if (ack_pulse) nxt = XF_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == XF_WAIT);
        done = (state == XF_WAIT) && ack_pulse;
    end
endmodule

// File: rtl/xmt_tick_core.sv
module xmt_tick_core
    import xmt_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic            tclk,
    input  logic            trst_n,
    input  logic            run_async,
    input  logic [XF_N-1:0] req_async,
    input  logic [CW-1:0]   cmp_in,
    input  logic [CW-1:0]   load_in,
    output logic [CW-1:0]   snap,
    output logic [XF_N-1:0] ack_tgl,
    output logic            hit_tgl,
    output logic            wrap_tgl
);
    logic [XF_N:0]   synced;
    logic [XF_N-1:0] req_d;
    logic [XF_N-1:0] req_edge;
    logic            run;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cmp_t;

    xmt_sync2 #(.W(XF_N + 1)) u_sync (
        .clk  (tclk),
        .rst_n(trst_n),
        .d    ({run_async, req_async}),
        .q    (synced)
    );

    assign run      = synced[XF_N];
    assign req_edge = synced[XF_N-1:0] ^ req_d;

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            req_d    <= '0;
            ack_tgl  <= '0;
            cnt      <= '0;
            cmp_t    <= '1;
            snap     <= '0;
            hit_tgl  <= 1'b0;
            wrap_tgl <= 1'b0;
        end else begin
            req_d <= synced[XF_N-1:0];
            if (req_edge[XF_CMP]) begin
                cmp_t           <= cmp_in;
                ack_tgl[XF_CMP] <= ~ack_tgl[XF_CMP];
            end
            if (req_edge[XF_SNAP]) begin
                snap             <= cnt;
                ack_tgl[XF_SNAP] <= ~ack_tgl[XF_SNAP];
            end
            if (req_edge[XF_LOAD]) begin
                cnt              <= load_in;
                ack_tgl[XF_LOAD] <= ~ack_tgl[XF_LOAD];
            end else if (run) begin
                cnt <= cnt + 1'b1;
            end
            if (run && cnt == cmp_t) hit_tgl  <= ~hit_tgl;
            if (run && &cnt)         wrap_tgl <= ~wrap_tgl;
        end
    end
endmodule

// File: rtl/xmt_timer.sv
module xmt_timer
    import xmt_pkg::*;
(
    input  logic              hclk,
    input  logic              hrst_n,
    input  logic              tclk,
    input  logic              trst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CNT_W-1:0]  host_wdata,
    output logic [CNT_W-1:0]  host_rdata,
    output logic              irq
);
    localparam int EV_N = XF_N + 2;

    logic              wr;
    logic              run_h;
    logic              ien;
    logic [FL_N-1:0]   flags;
    logic [CNT_W-1:0]  cmp_sh;
    logic [CNT_W-1:0]  load_sh;
    logic [CNT_W-1:0]  cnt_rd;
    logic [CNT_W-1:0]  snap_t;
    logic [XF_N-1:0]   start;
    logic [XF_N-1:0]   busy;
    logic [XF_N-1:0]   done;
    logic [XF_N-1:0]   req_tgl;
    logic [XF_N-1:0]   ack_tgl;
    logic              hit_tgl;
    logic              wrap_tgl;
    logic [EV_N-1:0]   ev_sync;
    logic [EV_N-1:0]   ev_d;
    logic [EV_N-1:0]   ev_edge;
    logic              hit_edge;
    logic              wrap_edge;
    logic [FL_N-1:0]   fl_set;
    logic [FL_N-1:0]   fl_clr;

    assign wr = host_sel && host_we;

    always_comb begin
        start          = '0;
        start[XF_CMP]  = wr && host_addr == REG_CMP;
        start[XF_LOAD] = wr && host_addr == REG_COUNT;
        start[XF_SNAP] = wr && host_addr == REG_CTRL && host_wdata[1];
    end

    for (genvar g = 0; g < XF_N; g++) begin : g_xfer
        xmt_xfer_fsm u_fsm (
            .clk      (hclk),
            .rst_n    (hrst_n),
            .start    (start[g]),
            .ack_pulse(ev_edge[g]),
            .req_tgl  (req_tgl[g]),
            .busy     (busy[g]),
            .done     (done[g])
        );
    end

    xmt_tick_core u_core (
        .tclk     (tclk),
        .trst_n   (trst_n),
        .run_async(run_h),
        .req_async(req_tgl),
        .cmp_in   (cmp_sh),
        .load_in  (load_sh),
        .snap     (snap_t),
        .ack_tgl  (ack_tgl),
        .hit_tgl  (hit_tgl),
        .wrap_tgl (wrap_tgl)
    );

    xmt_sync2 #(.W(EV_N)) u_back (
        .clk  (hclk),
        .rst_n(hrst_n),
        .d    ({wrap_tgl, hit_tgl, ack_tgl}),
        .q    (ev_sync)
    );

    assign ev_edge   = ev_sync ^ ev_d;
    assign hit_edge  = ev_edge[XF_N];
    assign wrap_edge = ev_edge[XF_N+1];

    always_comb begin
        fl_set             = '0;
        fl_set[FL_HIT]     = hit_edge;
        fl_set[FL_WRAP]    = wrap_edge;
        fl_set[FL_LOADED]  = done[XF_LOAD];
        fl_set[FL_CMPSET]  = done[XF_CMP];
        fl_clr = (wr && host_addr == REG_FLAGS) ? host_wdata[FL_N-1:0] : '0;
    end

    always_ff @(posedge hclk or negedge hrst_n) begin
        if (!hrst_n) begin
            ev_d    <= '0;
            run_h   <= 1'b0;
            ien     <= 1'b0;
            flags   <= '0;
            cmp_sh  <= '1;
            load_sh <= '0;
            cnt_rd  <= '0;
        end else begin
            ev_d  <= ev_sync;
            flags <= (flags & ~fl_clr) | fl_set;
            if (wr && host_addr == REG_CTRL) run_h <= host_wdata[0];
            if (wr && host_addr == REG_IEN)  ien   <= host_wdata[0];
            if (start[XF_CMP]  && !busy[XF_CMP])  cmp_sh  <= host_wdata;
            if (start[XF_LOAD] && !busy[XF_LOAD]) load_sh <= host_wdata;
            if (done[XF_SNAP]) cnt_rd <= snap_t;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            REG_CTRL:  host_rdata[0]        = run_h;
            REG_CMP:   host_rdata           = cmp_sh;
            REG_COUNT: host_rdata           = cnt_rd;
            REG_FLAGS: host_rdata[FL_N-1:0] = flags;
            REG_IEN:   host_rdata[0]        = ien;
            REG_BUSY:  host_rdata[XF_N-1:0] = busy;
            default:   host_rdata           = '0;
        endcase
    end

    assign irq = flags[FL_HIT] & ien;
endmodule

// File: rtl/xmt_timer_chk.sv
module xmt_timer_chk
    import xmt_pkg::*;
(
    input logic              hclk,
    input logic              hrst_n,
    input logic              host_sel,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [CNT_W-1:0]  host_wdata,
    input logic              irq,
    input logic              ien,
    input logic [FL_N-1:0]   flags,
    input logic [XF_N-1:0]   busy,
    input logic [CNT_W-1:0]  cmp_sh,
    input logic              hit_edge
);
    logic clr_hit;
    assign clr_hit = host_sel && host_we && host_addr == REG_FLAGS && host_wdata[FL_HIT] && !hit_edge;

    AST_CMP_BUSY_RISE: assert property (@(posedge hclk) disable iff (!hrst_n)
        (host_sel && host_we && host_addr == REG_CMP) |=> busy[XF_CMP]); // R4

    AST_SNAP_BUSY_RISE: assert property (@(posedge hclk) disable iff (!hrst_n)
        (host_sel && host_we && host_addr == REG_CTRL && host_wdata[1]) |=> busy[XF_SNAP]); // R3

    AST_CMP_HELD_WHILE_BUSY: assert property (@(posedge hclk) disable iff (!hrst_n)
        (busy[XF_CMP] && $past(busy[XF_CMP])) |-> $stable(cmp_sh)); // R6

    AST_HIT_CLEARED: assert property (@(posedge hclk) disable iff (!hrst_n)
        clr_hit |=> !flags[FL_HIT]); // R8

    AST_IRQ_DROPS: assert property (@(posedge hclk) disable iff (!hrst_n)
        clr_hit |=> !irq); // R9

    AST_IRQ_MASKED: assert property (@(posedge hclk) disable iff (!hrst_n)
        !ien |-> !irq); // R9
endmodule

bind xmt_timer xmt_timer_chk i_chk (
    .hclk      (hclk),
    .hrst_n    (hrst_n),
    .host_sel  (host_sel),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .irq       (irq),
    .ien       (ien),
    .flags     (flags),
    .busy      (busy),
    .cmp_sh    (cmp_sh),
    .hit_edge  (hit_edge)
);

// File: tb/test_xmt_timer.sv
`timescale 1ns/1ps
module test_xmt_timer;
    import xmt_pkg::*;

    logic        hclk = 1'b0;
    logic        tclk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        trst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 hclk = ~hclk;
    always #80 tclk = ~tclk;

    xmt_timer i_xmt_timer (
        .hclk(hclk), .hrst_n(hrst_n), .tclk(tclk), .trst_n(trst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] start;
        logic [31:0] cmp;
        logic [15:0] ticks;
        logic        hit;
        logic        wrap;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'd100,        32'd105,  16'd30, 1'b1, 1'b0},
        '{32'd500,        32'd497,  16'd30, 1'b0, 1'b0},
        '{32'd0,          32'd300,  16'd30, 1'b0, 1'b0},
        '{32'hFFFF_FFF8,  32'd3,    16'd30, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge hclk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge hclk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(input int b, input string req);
        logic [31:0] v;
        int n = 0;
        rd(REG_BUSY, v);
        while (v[b] && n < 500) begin
            @(negedge hclk);
            rd(REG_BUSY, v);
            n++;
        end
        check(!v[b], req, v, 32'h0);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] s1;
        repeat (3) @(negedge tclk);
        hrst_n = 1'b1; trst_n = 1'b1;
        @(negedge hclk);

        // R1 reset state
        rd(REG_CMP, v);   check(v == 32'hFFFF_FFFF, "R1 compare", v, 32'hFFFF_FFFF);
        rd(REG_COUNT, v); check(v == 0, "R1 count", v, 0);
        rd(REG_FLAGS, v); check(v == 0, "R1 flags", v, 0);
        rd(REG_IEN, v);   check(v == 0, "R1 ien", v, 0);
        rd(REG_CTRL, v);  check(v == 0, "R1 ctrl", v, 0);
        rd(REG_BUSY, v);  check(v == 0, "R1 busy", v, 0);
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);

        // R5 count load, R3 exact snapshot of a stopped counter
        wr(REG_COUNT, 32'h1234_5678);
        rd(REG_BUSY, v); check(v[1] == 1'b1, "R5 load busy", v, 32'h2);
        wait_idle(1, "R5 load busy clears");
        rd(REG_FLAGS, v); check(v[2] == 1'b1, "R5 loaded flag", v, 32'h4);
        wr(REG_CTRL, 32'h2);
        rd(REG_BUSY, v); check(v[2] == 1'b1, "R3 snap busy", v, 32'h4);
        wait_idle(2, "R3 snap busy clears");
        rd(REG_COUNT, v); check(v == 32'h1234_5678, "R3 snapshot value", v, 32'h1234_5678);

        // R4 compare busy and flag, R6 second write while busy is dropped
        wr(REG_FLAGS, 32'hF);
        wr(REG_CMP, 32'hAAAA_0000);
        rd(REG_BUSY, v); check(v[0] == 1'b1, "R4 cmp busy", v, 32'h1);
        wr(REG_CMP, 32'h0000_5555);
        wait_idle(0, "R4 cmp busy clears");
        rd(REG_CMP, v); check(v == 32'hAAAA_0000, "R6 ignored write", v, 32'hAAAA_0000);
        rd(REG_FLAGS, v); check(v[3] == 1'b1, "R4 cmp flag", v, 32'h8);

        // R2 R7 table of run windows
        foreach (VECS[i]) begin
            wr(REG_CTRL, 32'h0);
            repeat (6) @(negedge tclk);
            wr(REG_COUNT, VECS[i].start);
            wait_idle(1, "R5 load");
            wr(REG_CMP, VECS[i].cmp);
            wait_idle(0, "R4 cmp");
            wr(REG_FLAGS, 32'hF);
            wr(REG_CTRL, 32'h1);
            repeat (VECS[i].ticks) @(negedge tclk);
            wr(REG_CTRL, 32'h0);
            repeat (6) @(negedge tclk);
            @(negedge hclk);
            rd(REG_FLAGS, v);
            check(v[0] == VECS[i].hit, "R7 hit flag", v, {31'b0, VECS[i].hit});
            check(v[1] == VECS[i].wrap, "R7 wrap flag", v, {30'b0, VECS[i].wrap, 1'b0});
            wr(REG_CTRL, 32'h2);
            wait_idle(2, "R3 snap");
            rd(REG_COUNT, v);
            s1 = v - VECS[i].start;
            check(s1 >= 25 && s1 <= 35, "R2 ticks advanced", s1, 32'd30);
        end

        // R2 stopped counter holds
        rd(REG_COUNT, s1);
        repeat (20) @(negedge tclk);
        wr(REG_CTRL, 32'h2);
        wait_idle(2, "R3 snap");
        rd(REG_COUNT, v); check(v == s1, "R2 stopped holds", v, s1);

        // R8 selective clear: flags now hit and wrap (0x3)
        wr(REG_FLAGS, 32'h2);
        rd(REG_FLAGS, v); check(v == 32'h1, "R8 clear wrap only", v, 32'h1);

        // R9 interrupt gating and drop
        check(irq == 1'b0, "R9 masked", {31'b0, irq}, 0);
        wr(REG_IEN, 32'h1);
        check(irq == 1'b1, "R9 enabled", {31'b0, irq}, 1);
        wr(REG_FLAGS, 32'h1);
        check(irq == 1'b0, "R9 drop after clear", {31'b0, irq}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule